// File: doc/BRIEF.md
# Asynchronous Pseudo-SRAM Access Controller

This block connects a synchronous request port to an external 1M x 16 pseudo-SRAM. The memory has a DRAM core and a plain asynchronous SRAM-style bus: active-low chip enable, output enable, write enable, two byte strobes and a 16-bit data bus. The bus is split into `mem_dq_out`, `mem_dq_oe` and `mem_dq_in`, and the tri-state pad sits outside the block.

After reset the controller waits out the memory's self-initialization interval. During that interval chip enable stays high and no request is accepted. After that, every accepted request becomes one single asynchronous access. The access time, the write pulse width and the recovery gap are set by parameters and counted in clock cycles.

Chip enable is lowered once per access and raised again between accesses. This lets the memory's internal refresh run and bounds the time chip enable spends low. A read returns its data with a one-cycle valid pulse. Lanes that the byte enables did not select read back as zero.

Top module: `psram_async_ctrl`

## Requirements
- R1: From reset until `CLK_MHZ*INIT_US` rising clock edges have passed, `mem_ce_n` stays 1, `req_ready` stays 0 and `init_done` stays 0. At exactly that edge count, `init_done` and `req_ready` become 1.
- R2: During a read (`req_write`=0), `mem_ce_n` and `mem_oe_n` are 0 and `mem_we_n` is 1 for exactly `ACCESS_CYC` cycles. `mem_addr` equals the request address for the whole access.
- R3: Read data is sampled at the end of the `ACCESS_CYC`-th cycle of chip enable low. `rsp_valid` is then high for exactly one cycle. Bits 7:0 of `rsp_rdata` are zero unless `req_be[0]` was set, and bits 15:8 are zero unless `req_be[1]` was set.
- R4: During a write (`req_write`=1), `mem_ce_n` and `mem_we_n` are 0, `mem_oe_n` is 1 and `mem_dq_oe` is 1 for exactly `WR_PULSE_CYC` cycles. Only the selected strobes go low: `req_be[0]` drives `mem_lb_n` (bits 7:0) and `req_be[1]` drives `mem_ub_n` (bits 15:8). A lane whose strobe stays high keeps its old content.
- R5: When `mem_we_n` rises, `mem_dq_oe` is still 1 and `mem_addr` and `mem_dq_out` are unchanged. The memory therefore captures the requested data.
- R6: `mem_dq_oe` is 0 whenever `mem_oe_n` is 0. It is also 0 in the cycle before `mem_oe_n` falls.
- R7: Every chip-enable-low period lasts at most `CE_LOW_MAX_CYC` cycles. Chip enable is high for at least `RECOVER_CYC` cycles between two accesses, even for back-to-back requests.
- R8: `req_ready` is 1 only while the bus is idle. A request held while `req_ready` is 0, including during initialization, is accepted later and carried out, never dropped. A request presented right after a write waits exactly `WR_PULSE_CYC+RECOVER_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte, bit 1 = high byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| init_done | output | 1 | Initialization interval over |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte strobe, active low |
| mem_ub_n | output | 1 | High byte strobe, active low |
| mem_dq_out | output | 16 | Data driven to the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
Full-word and single-lane writes are tried first. Comparing them separates correct strobe selection from a design that always writes both bytes. Reads with one lane enabled separate lane zeroing from a raw pass-through of the bus, which the memory model fills with a marker value. The model also returns garbage until the access time has fully run, so sampling one cycle early is caught. A write followed immediately by a read, with valid held, checks the exact stall length, the recovery gap and the bus turnaround. A write held during initialization shows that a stalled request is kept and not dropped.

// File: rtl/psram_ctrl_pkg.sv
`timescale 1ns/1ps
package psram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_INIT    = 3'd0,
      ST_IDLE    = 3'd1,
      ST_READ    = 3'd2,
      ST_WRITE   = 3'd3,
      ST_RECOVER = 3'd4
   } pctl_state_t;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit > 1) ? $clog2(limit) : 1;
   endfunction

endpackage

// File: rtl/psram_init_timer.sv
`timescale 1ns/1ps
module psram_init_timer #(
   parameter int unsigned INIT_CYCLES = 7500
) (
   input  logic clk,
   input  logic rst_n,
   output logic expire
);
   generate
      if (INIT_CYCLES <= 1) begin : g_immediate
         logic seen_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) seen_q <= 1'b0;
            else        seen_q <= 1'b1;
         end
         assign expire = seen_q | 1'b1;
      end else begin : g_count
         localparam int unsigned CW = $clog2(INIT_CYCLES);
         localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
         end
         assign expire = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/psram_access_fsm.sv
`timescale 1ns/1ps
module psram_access_fsm
   import psram_ctrl_pkg::*;
#(
   parameter int unsigned ACCESS_CYC   = 4,
   parameter int unsigned WR_PULSE_CYC = 3,
   parameter int unsigned RECOVER_CYC  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic init_expire,
   input  logic req_valid,
   input  logic req_write,
   output logic req_ready,
   output logic accept,
   output logic sample,
   output logic lane_on_d,
   output logic running,
   output logic ce_n,
   output logic oe_n,
   output logic we_n,
   output logic dq_oe
);
   localparam int unsigned MAXC = max3(ACCESS_CYC, WR_PULSE_CYC, RECOVER_CYC);
   localparam int unsigned CW   = cnt_width(MAXC);
   localparam logic [CW-1:0] ACC_LAST = CW'(ACCESS_CYC - 1);
   localparam logic [CW-1:0] WR_LAST  = CW'(WR_PULSE_CYC - 1);
   localparam logic [CW-1:0] REC_LAST = CW'(RECOVER_CYC - 1);

   pctl_state_t   st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d   = st_q;
      cnt_d  = cnt_q;
      sample = 1'b0;
      case (st_q)
         ST_INIT: begin
            if (init_expire) st_d = ST_IDLE;
         end
         ST_IDLE: begin
            if (req_valid) begin
               st_d  = req_write ? ST_WRITE : ST_READ;
               cnt_d = '0;
            end
         end
         ST_READ: begin
            if (cnt_q == ACC_LAST) begin
               st_d   = ST_RECOVER;
               cnt_d  = '0;
               sample = 1'b1;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_WRITE: begin
            if (cnt_q == WR_LAST) begin
               st_d  = ST_RECOVER;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_RECOVER: begin
            if (cnt_q == REC_LAST) begin
               st_d  = ST_IDLE;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: st_d = ST_INIT;
      endcase
   end

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_ready & req_valid;
   assign running   = (st_q != ST_INIT);
   assign lane_on_d = (st_d == ST_READ) || (st_d == ST_WRITE);

   // Strobes are registered from the next state so the pads see clean edges.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_INIT;
         cnt_q <= '0;
         ce_n  <= 1'b1;
         oe_n  <= 1'b1;
         we_n  <= 1'b1;
         dq_oe <= 1'b0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
         ce_n  <= !lane_on_d;
         oe_n  <= !(st_d == ST_READ);
         we_n  <= !(st_d == ST_WRITE);
         // drive also through the first recovery cycle after a write pulse
         dq_oe <= (st_d == ST_WRITE) || ((st_q == ST_WRITE) && (st_d == ST_RECOVER));
      end
   end
endmodule

// File: rtl/psram_lane_path.sv
`timescale 1ns/1ps
module psram_lane_path #(
   parameter int unsigned LANES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               accept,
   input  logic [LANES-1:0]   req_be,
   input  logic [LANES*8-1:0] req_wdata,
   input  logic               lane_on_d,
   input  logic               sample,
   input  logic [LANES*8-1:0] mem_dq_in,
   output logic [LANES-1:0]   lane_n,
   output logic [LANES*8-1:0] dq_out,
   output logic               rsp_valid,
   output logic [LANES*8-1:0] rsp_rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsp_valid <= 1'b0;
      else        rsp_valid <= sample;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic       be_q, strobe_n_q;
      logic [7:0] wd_q, rd_q;
      logic       be_d;

      assign be_d = accept ? req_be[l] : be_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            be_q       <= 1'b0;
            strobe_n_q <= 1'b1;
            wd_q       <= '0;
            rd_q       <= '0;
         end else begin
            be_q       <= be_d;
            strobe_n_q <= !(lane_on_d && be_d);
            if (accept) wd_q <= req_wdata[l*8 +: 8];
            if (sample) rd_q <= be_q ? mem_dq_in[l*8 +: 8] : 8'h00;
         end
      end

      assign lane_n[l]          = strobe_n_q;
      assign dq_out[l*8 +: 8]   = wd_q;
      assign rsp_rdata[l*8 +: 8] = rd_q;
   end
endmodule

// File: rtl/psram_async_ctrl.sv
`timescale 1ns/1ps
module psram_async_ctrl #(
   parameter int unsigned ADDR_W         = 20,
   parameter int unsigned CLK_MHZ        = 50,
   parameter int unsigned INIT_US        = 150,
   parameter int unsigned ACCESS_CYC     = 4,
   parameter int unsigned WR_PULSE_CYC   = 3,
   parameter int unsigned RECOVER_CYC    = 2,
   parameter int unsigned CE_LOW_MAX_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [15:0]       req_wdata,
   input  logic [1:0]        req_be,
   output logic              rsp_valid,
   output logic [15:0]       rsp_rdata,
   output logic              init_done,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic              mem_lb_n,
   output logic              mem_ub_n,
   output logic [15:0]       mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [15:0]       mem_dq_in
);
   localparam int unsigned DATA_W      = 16;
   localparam int unsigned LANES       = DATA_W / 8;
   localparam int unsigned INIT_CYCLES = CLK_MHZ * INIT_US;

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W out of range");
   end
   if (ACCESS_CYC < 1 || WR_PULSE_CYC < 1) begin : g_bad_pulse
      $error("access and write pulse need at least one cycle");
   end
   if (RECOVER_CYC < 2) begin : g_bad_recover
      $error("RECOVER_CYC must be at least 2 for bus turnaround");
   end
   if (ACCESS_CYC > CE_LOW_MAX_CYC || WR_PULSE_CYC > CE_LOW_MAX_CYC) begin : g_bad_cem
      $error("an access would hold chip enable low too long");
   end
   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("initialization interval must be nonzero");
   end

   logic             init_expire, accept, sample, lane_on_d;
   logic [LANES-1:0] lane_n;
   logic [ADDR_W-1:0] addr_q;

   psram_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_init (
      .clk    (clk),
      .rst_n  (rst_n),
      .expire (init_expire)
   );

   psram_access_fsm #(
      .ACCESS_CYC   (ACCESS_CYC),
      .WR_PULSE_CYC (WR_PULSE_CYC),
      .RECOVER_CYC  (RECOVER_CYC)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .init_expire (init_expire),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_ready   (req_ready),
      .accept      (accept),
      .sample      (sample),
      .lane_on_d   (lane_on_d),
      .running     (init_done),
      .ce_n        (mem_ce_n),
      .oe_n        (mem_oe_n),
      .we_n        (mem_we_n),
      .dq_oe       (mem_dq_oe)
   );

   psram_lane_path #(.LANES(LANES)) u_lanes (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .req_be    (req_be),
      .req_wdata (req_wdata),
      .lane_on_d (lane_on_d),
      .sample    (sample),
      .mem_dq_in (mem_dq_in),
      .lane_n    (lane_n),
      .dq_out    (mem_dq_out),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (accept) addr_q <= req_addr;
   end

   assign mem_addr = addr_q;
   assign mem_lb_n = lane_n[0];
   assign mem_ub_n = lane_n[1];
endmodule

// File: rtl/psram_ctrl_checker.sv
`timescale 1ns/1ps
module psram_ctrl_checker #(
   parameter int unsigned ADDR_W         = 20,
   parameter int unsigned RECOVER_CYC    = 2,
   parameter int unsigned CE_LOW_MAX_CYC = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              init_done,
   input logic              rsp_valid,
   input logic              mem_ce_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              mem_lb_n,
   input logic              mem_ub_n,
   input logic              mem_dq_oe,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [15:0]       mem_dq_out
);
   localparam int unsigned LW = $clog2(CE_LOW_MAX_CYC + 2);
   localparam int unsigned HW = $clog2(RECOVER_CYC + 1);
   localparam logic [LW-1:0] LO_SAT = LW'(CE_LOW_MAX_CYC + 1);
   localparam logic [HW-1:0] HI_SAT = HW'(RECOVER_CYC);

   logic [LW-1:0] lo_cnt;
   logic [HW-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt <= '0;
         hi_cnt <= HI_SAT;
      end else begin
         if (mem_ce_n)             lo_cnt <= '0;
         else if (lo_cnt != LO_SAT) lo_cnt <= lo_cnt + 1'b1;
         if (!mem_ce_n)            hi_cnt <= '0;
         else if (hi_cnt != HI_SAT) hi_cnt <= hi_cnt + 1'b1;
      end
   end

   assert_init_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> (mem_ce_n && !req_ready));

   assert_read_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!mem_ce_n && mem_we_n));

   assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_write_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

   assert_idle_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce_n |-> (mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n));

   assert_write_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out)));

   assert_bus_turn_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!mem_dq_oe && !$past(mem_dq_oe)));

   assert_ce_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lo_cnt <= LW'(CE_LOW_MAX_CYC));

   assert_ce_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_ce_n) |-> (hi_cnt >= HW'(RECOVER_CYC)));

   assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && !mem_dq_oe));
endmodule

bind psram_async_ctrl psram_ctrl_checker #(
   .ADDR_W         (ADDR_W),
   .RECOVER_CYC    (RECOVER_CYC),
   .CE_LOW_MAX_CYC (CE_LOW_MAX_CYC)
) u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .init_done  (init_done),
   .rsp_valid  (rsp_valid),
   .mem_ce_n   (mem_ce_n),
   .mem_oe_n   (mem_oe_n),
   .mem_we_n   (mem_we_n),
   .mem_lb_n   (mem_lb_n),
   .mem_ub_n   (mem_ub_n),
   .mem_dq_oe  (mem_dq_oe),
   .mem_addr   (mem_addr),
   .mem_dq_out (mem_dq_out)
);

// File: tb/test_psram_async_ctrl.sv
`timescale 1ns/1ps
module test_psram_async_ctrl;
   localparam int CLK_MHZ = 50;
   localparam int INIT_US = 150;
   localparam int INIT_CYC = CLK_MHZ * INIT_US;
   localparam int ACC = 4;
   localparam int WRP = 3;
   localparam int REC = 2;
   localparam int CEM = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n, req_valid, req_ready, req_write, rsp_valid, init_done;
   logic [19:0] req_addr, mem_addr;
   logic [15:0] req_wdata, rsp_rdata, mem_dq_out, mem_dq_in;
   logic [1:0]  req_be;
   logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;

   psram_async_ctrl #(
      .ADDR_W(20), .CLK_MHZ(CLK_MHZ), .INIT_US(INIT_US), .ACCESS_CYC(ACC),
      .WR_PULSE_CYC(WRP), .RECOVER_CYC(REC), .CE_LOW_MAX_CYC(CEM)
   ) i_psram_async_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .init_done(init_done), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n),
      .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   int n_checks = 0;
   int n_fail   = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // memory model and bus monitor
   logic [15:0] mem [64];
   int ce_run = 0, last_run = 0, acc_done = 0, ce_hi = 0, last_gap = 0;
   int init_ce_low = 0, bus_clash = 0, strobe_unstable = 0, rd_cnt = 0;
   int rsp_cnt = 0, rsp_long = 0, hold_bad = 0;
   logic snap_oe, snap_we, snap_lb, snap_ub;
   logic [19:0] snap_addr;
   logic [15:0] rsp_last;
   logic p_ce = 1'b1, p_we = 1'b1, p_lb = 1'b1, p_ub = 1'b1, p_dq = 1'b0, p_rsp = 1'b0;

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h0101) ^ 16'h3C00;
   end

   assign mem_dq_in[7:0]  = (!mem_ce_n && !mem_oe_n && !mem_lb_n && rd_cnt >= ACC)
                            ? mem[mem_addr[5:0]][7:0] : 8'h5A;
   assign mem_dq_in[15:8] = (!mem_ce_n && !mem_oe_n && !mem_ub_n && rd_cnt >= ACC)
                            ? mem[mem_addr[5:0]][15:8] : 8'h5A;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!init_done && !mem_ce_n) init_ce_low++;
         if (!mem_oe_n && (mem_dq_oe || p_dq)) bus_clash++;
         if (!mem_ce_n) begin
            if (ce_run == 0) begin
               snap_oe = mem_oe_n; snap_we = mem_we_n; snap_lb = mem_lb_n;
               snap_ub = mem_ub_n; snap_addr = mem_addr; last_gap = ce_hi;
            end else if (snap_oe != mem_oe_n || snap_we != mem_we_n ||
                         snap_lb != mem_lb_n || snap_ub != mem_ub_n ||
                         snap_addr != mem_addr) begin
               strobe_unstable++;
            end
            ce_run++;
            ce_hi = 0;
         end else begin
            if (ce_run > 0) begin
               last_run = ce_run;
               acc_done++;
            end
            ce_run = 0;
            ce_hi++;
         end
         if (!mem_ce_n && !mem_oe_n) rd_cnt++; else rd_cnt = 0;
         if (!p_ce && !p_we && !p_lb && (mem_ce_n || mem_we_n || mem_lb_n)) begin
            if (mem_dq_oe) mem[mem_addr[5:0]][7:0] = mem_dq_out[7:0];
            else begin mem[mem_addr[5:0]][7:0] = 8'hEE; hold_bad++; end
         end
         if (!p_ce && !p_we && !p_ub && (mem_ce_n || mem_we_n || mem_ub_n)) begin
            if (mem_dq_oe) mem[mem_addr[5:0]][15:8] = mem_dq_out[15:8];
            else begin mem[mem_addr[5:0]][15:8] = 8'hEE; hold_bad++; end
         end
         if (rsp_valid) begin
            rsp_cnt++;
            rsp_last = rsp_rdata;
            if (p_rsp) rsp_long++;
         end
      end
      p_ce = mem_ce_n; p_we = mem_we_n; p_lb = mem_lb_n; p_ub = mem_ub_n;
      p_dq = mem_dq_oe; p_rsp = rsp_valid;
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic issue(input bit wr, input logic [19:0] a, input logic [15:0] d,
                        input logic [1:0] be, output int stalls);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      stalls = 0;
      while (!req_ready && stalls < 1000) begin
         step();
         stalls++;
      end
      step();
      req_valid = 1'b0;
   endtask

   task automatic wait_access(input int target);
      for (int k = 0; k < 100 && acc_done < target; k++) step();
   endtask

   task automatic wait_rsp(input int target);
      for (int k = 0; k < 100 && rsp_cnt < target; k++) step();
   endtask

   task automatic t_init_hold();
      logic [15:0] exp;
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_addr = '0; req_wdata = '0; req_be = '0;
      repeat (3) step();
      check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1", "reset strobes",
            {28'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 32'he);
      check(!req_ready && !rsp_valid && !init_done, "R1", "reset ready/rsp/init",
            {29'd0, req_ready, rsp_valid, init_done}, 32'h0);
      rst_n = 1'b1;
      // request held through the whole initialization (R8)
      req_valid = 1'b1; req_write = 1'b1; req_addr = 20'hABC05;
      req_wdata = 16'h1234; req_be = 2'b11;
      for (int i = 1; i <= INIT_CYC; i++) begin
         step();
         if (i == INIT_CYC - 1)
            check(!init_done && !req_ready, "R1", "still initializing one edge early",
                  {30'd0, init_done, req_ready}, 32'h0);
      end
      check(init_done && req_ready, "R1", "init over at exact edge count",
            {30'd0, init_done, req_ready}, 32'h3);
      check(init_ce_low == 0, "R1", "chip enable low during init", init_ce_low, 0);
      step();
      req_valid = 1'b0;
      wait_access(1);
      step();
      exp = 16'h1234;
      check(mem[5] == exp, "R8", "request held over init written", mem[5], exp);
   endtask

   task automatic t_write_full();
      int st, base;
      base = acc_done;
      issue(1'b1, 20'h4_0009, 16'hBEEF, 2'b11, st);
      wait_access(base + 1);
      check(last_run == WRP && !snap_we && snap_oe, "R4", "write pulse length/strobes",
            last_run, WRP);
      check(!snap_lb && !snap_ub, "R4", "both lanes strobed", {snap_lb, snap_ub}, 0);
      check(mem[9] == 16'hBEEF && hold_bad == 0, "R5", "write data captured",
            mem[9], 16'hBEEF);
   endtask

   task automatic t_write_lane();
      int st, base;
      logic [15:0] exp;
      base = acc_done;
      exp = {mem[9][15:8], 8'h77};
      issue(1'b1, 20'h4_0009, 16'h6677, 2'b01, st);
      wait_access(base + 1);
      check(!snap_lb && snap_ub, "R4", "only low lane strobed", {snap_lb, snap_ub}, 32'h1);
      check(mem[9] == exp, "R4", "high lane untouched", mem[9], exp);
   endtask

   task automatic t_read_full();
      int st, base, rb;
      logic [15:0] exp;
      base = acc_done; rb = rsp_cnt;
      exp = mem[9];
      issue(1'b0, 20'hF_3C09, 16'h0000, 2'b11, st);
      wait_rsp(rb + 1);
      step(); step();
      check(last_run == ACC && !snap_oe && snap_we, "R2", "read strobes and length",
            last_run, ACC);
      check(snap_addr == 20'hF_3C09 && strobe_unstable == 0, "R2", "address held",
            snap_addr, 20'hF_3C09);
      check(rsp_last == exp, "R3", "full word read", rsp_last, exp);
      check(rsp_cnt == rb + 1 && rsp_long == 0, "R3", "single valid pulse",
            rsp_cnt - rb, 1);
      check(acc_done == base + 1 && last_run <= CEM, "R7", "chip enable low bound",
            last_run, CEM);
   endtask

   task automatic t_read_lane();
      int st, rb;
      logic [15:0] exp;
      rb = rsp_cnt;
      exp = {mem[17][15:8], 8'h00};
      issue(1'b0, 20'h0_0011, 16'h0000, 2'b10, st);
      wait_rsp(rb + 1);
      check(rsp_last == exp, "R3", "low lane zeroed", rsp_last, exp);
      rb = rsp_cnt;
      exp = {8'h00, mem[17][7:0]};
      issue(1'b0, 20'h0_0011, 16'h0000, 2'b01, st);
      wait_rsp(rb + 1);
      check(rsp_last == exp, "R3", "high lane zeroed", rsp_last, exp);
   endtask

   task automatic t_back_to_back();
      int st1, st2, rb;
      logic [15:0] exp;
      rb = rsp_cnt;
      issue(1'b1, 20'h2_0022, 16'hC0DE, 2'b11, st1);
      issue(1'b0, 20'h2_0022, 16'h0000, 2'b11, st2);
      check(st2 == WRP + REC, "R8", "stall after write", st2, WRP + REC);
      wait_rsp(rb + 1);
      exp = 16'hC0DE;
      check(rsp_last == exp, "R8", "read after write not dropped", rsp_last, exp);
      check(last_gap >= REC, "R7", "recovery gap between accesses", last_gap, REC);
      check(bus_clash == 0, "R6", "bus driven near output enable", bus_clash, 0);
      check(hold_bad == 0, "R5", "drive held at write strobe release", hold_bad, 0);
   endtask

   initial begin
      #(20ns * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      t_init_hold();
      t_write_full();
      t_write_lane();
      t_read_full();
      t_read_lane();
      t_back_to_back();
      repeat (4) step();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule